// File: doc/BRIEF.md
# Binary64 Round-and-Pack Result Selector

This block takes the output of a floating-point datapath before its exponent has been bounded. That output is a sign, a biased exponent that may fall outside the encodable range, a normalized 53-bit significand with the hidden one at bit 52, and a guard bit and a sticky bit. From these it forms the final binary64 word and the overflow, underflow and inexact flags. The caller chooses one of four rounding modes on a two-bit input and ORs the three flags into its own sticky status.

Inputs whose exponent is below the normal range are shifted right into the denormal field before rounding, and the bits shifted out are folded into guard and sticky. Each result is rounded by adding one to the packed exponent and fraction, so a carry out of the fraction moves into the exponent. Overflow is checked both before and after that increment. On overflow the output is either infinity or the largest finite value, picked from the mode and the sign. The result is registered one cycle after the input strobe.

Top module: `fpr_round_pack`

## Requirements
- R1: When `valid_i` is high, the result and flags appear at the next rising clock edge and `valid_o` is high for that cycle. When `valid_i` is low, `result_o` and the flags keep their values and `valid_o` is low. Reset clears every output to zero.
- R2: Mode `rmode_i`=2'b00 rounds to nearest with ties to even: the value increments when the guard bit is 1 and either the sticky bit or the fraction LSB is 1. `inexact_o` is raised whenever guard or sticky is 1.
- R3: Mode 2'b01 truncates. Mode 2'b10 rounds toward +infinity, so a positive inexact value increments. Mode 2'b11 rounds toward -infinity, so a negative inexact value increments in magnitude.
- R4: A round increment that carries out of the fraction raises the exponent by one. Overflow is decided again after that carry.
- R5: A nonzero input with biased exponent at or above 2047, or one whose rounding carries to exponent 2047, is an overflow. It raises `overflow_o` and `inexact_o`. For a positive sign the result is +infinity (0x7FF0000000000000) in modes 00 and 10, and 0x7FEFFFFFFFFFFFFF in modes 01 and 11.
- R6: For a negative overflow, modes 10 and 11 swap roles: the result is -infinity in modes 00 and 11, and 0xFFEFFFFFFFFFFFFF in modes 01 and 10.
- R7: A nonzero input with biased exponent e at or below 0 is shifted right by 1-e into the denormal field (exponent field 0) and then rounded. Rounding may carry it up to the smallest normal, 0x0010000000000000.
- R8: An input is tiny when its exponent is at or below 0 before rounding. Underflow is raised only for a tiny input that is also inexact. A tiny exact input raises no flag.
- R9: A tiny input far below the denormal range gives signed zero, or the smallest denormal (magnitude 0x1) in the mode that rounds away from zero for that sign. Underflow and inexact are raised.
- R10: An all-zero significand gives a zero with the input sign and no flags, whatever the exponent, guard and sticky inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input strobe, one operation per high cycle |
| sign_i | input | 1 | Sign of the intermediate result |
| exp_i | input | 13 | Biased exponent, two's complement, unbounded |
| sig_i | input | 53 | Normalized significand, hidden one at bit 52 |
| guard_i | input | 1 | First bit below the significand LSB |
| sticky_i | input | 1 | OR of all bits below the guard bit |
| rmode_i | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| valid_o | output | 1 | Result strobe |
| result_o | output | 64 | Packed binary64 result |
| overflow_o | output | 1 | Overflow flag |
| underflow_o | output | 1 | Underflow flag |
| inexact_o | output | 1 | Inexact flag |

## Verification
The single output register sits behind purely combinational logic, so any wrong shift count, round decision or overflow choice shows at the ports in the cycle after the strobe. A faulty denormal shift shows up as a wrong fraction or a missing guard bit, and only when the exponent is at or below zero, which is why the bench sweeps exponents 0, -51, -52 and far below. A carry that fails to reach the exponent shows as a result one binade too low. An overflow check that skips the post-increment case shows as a finite 0x7FF-exponent pattern with the overflow flag low.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_UP      = 2'b10,
    RM_DOWN    = 2'b11
  } rmode_e;
endpackage

// File: rtl/fpr_denorm.sv
module fpr_denorm #(
  parameter int EXP_W  = 11,
  parameter int MAN_W  = 52,
  parameter int EIN_W  = 13
) (
  input  logic [EIN_W-1:0] exp_i,
  input  logic [MAN_W:0]   sig_i,
  input  logic             guard_i,
  input  logic             sticky_i,
  output logic             tiny_o,
  output logic             hidden_o,
  output logic [MAN_W-1:0] frac_o,
  output logic             guard_o,
  output logic             sticky_o
);
  localparam int SIG_W = MAN_W + 1;
  localparam int WIN_W = SIG_W + 1;
  localparam int SH_W  = $clog2(WIN_W + 1);

  logic [EIN_W-1:0]   sh_full;
  logic [SH_W-1:0]    sh_sat;
  logic [2*WIN_W-1:0] win;
  logic [2*WIN_W-1:0] shifted;

  // exponent <= 0 (two's complement) means below the normal range
  assign tiny_o  = exp_i[EIN_W-1] | (exp_i == '0);
  assign sh_full = EIN_W'(1) - exp_i;

  // beyond WIN_W every bit already lands in sticky
  always_comb begin
    if (!tiny_o)                          sh_sat = '0;
    else if (sh_full > EIN_W'(WIN_W))     sh_sat = SH_W'(WIN_W);
    else                                  sh_sat = sh_full[SH_W-1:0];
  end

  assign win      = {sig_i, guard_i, {WIN_W{1'b0}}};
  assign shifted  = win >> sh_sat;
  assign hidden_o = shifted[2*WIN_W-1];
  assign frac_o   = shifted[2*WIN_W-2:WIN_W+1];
  assign guard_o  = shifted[WIN_W];
  assign sticky_o = (|shifted[WIN_W-1:0]) | sticky_i;
endmodule

// File: rtl/fpr_round_inc.sv
module fpr_round_inc
  import fpr_pkg::*;
(
  input  rmode_e rmode_i,
  input  logic   sign_i,
  input  logic   lsb_i,
  input  logic   guard_i,
  input  logic   sticky_i,
  output logic   inc_o,
  output logic   inexact_o
);
  assign inexact_o = guard_i | sticky_i;

  always_comb begin
    unique case (rmode_i)
      RM_NEAREST: inc_o = guard_i & (sticky_i | lsb_i);
      RM_ZERO:    inc_o = 1'b0;
      RM_UP:      inc_o = ~sign_i & inexact_o;
      RM_DOWN:    inc_o = sign_i & inexact_o;
      default:    inc_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpr_ovf_sel.sv
module fpr_ovf_sel
  import fpr_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  rmode_e                 rmode_i,
  input  logic                   sign_i,
  output logic [EXP_W+MAN_W-1:0] mag_o
);
  localparam logic [EXP_W+MAN_W-1:0] INF_MAG  = {{EXP_W{1'b1}}, {MAN_W{1'b0}}};
  localparam logic [EXP_W+MAN_W-1:0] MAXF_MAG = {{(EXP_W-1){1'b1}}, 1'b0, {MAN_W{1'b1}}};

  logic to_inf;

  // infinity only when rounding pushes away from zero for this sign
  always_comb begin
    unique case (rmode_i)
      RM_NEAREST: to_inf = 1'b1;
      RM_ZERO:    to_inf = 1'b0;
      RM_UP:      to_inf = ~sign_i;
      RM_DOWN:    to_inf = sign_i;
      default:    to_inf = 1'b1;
    endcase
  end

  assign mag_o = to_inf ? INF_MAG : MAXF_MAG;
endmodule

// File: rtl/fpr_round_pack.sv
module fpr_round_pack
  import fpr_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int EIN_W = 13
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic                   sign_i,
  input  logic [EIN_W-1:0]       exp_i,
  input  logic [MAN_W:0]         sig_i,
  input  logic                   guard_i,
  input  logic                   sticky_i,
  input  logic [1:0]             rmode_i,
  output logic                   valid_o,
  output logic [EXP_W+MAN_W:0]   result_o,
  output logic                   overflow_o,
  output logic                   underflow_o,
  output logic                   inexact_o
);
  localparam int MAG_W     = EXP_W + MAN_W;
  localparam int MAX_FIELD = (1 << EXP_W) - 1;
  localparam logic [MAG_W-1:0] INF_MAG  = {{EXP_W{1'b1}}, {MAN_W{1'b0}}};
  localparam logic [MAG_W-1:0] MAXF_MAG = {{(EXP_W-1){1'b1}}, 1'b0, {MAN_W{1'b1}}};

  rmode_e rmode;
  assign rmode = rmode_e'(rmode_i);

  logic             zero_in;
  logic             tiny;
  logic             den_hidden;
  logic [MAN_W-1:0] den_frac;
  logic             den_guard;
  logic             den_sticky;

  assign zero_in = ~|sig_i;

  fpr_denorm #(
    .EXP_W(EXP_W), .MAN_W(MAN_W), .EIN_W(EIN_W)
  ) u_denorm (
    .exp_i   (exp_i),
    .sig_i   (sig_i),
    .guard_i (guard_i),
    .sticky_i(sticky_i),
    .tiny_o  (tiny),
    .hidden_o(den_hidden),
    .frac_o  (den_frac),
    .guard_o (den_guard),
    .sticky_o(den_sticky)
  );

  logic rnd_inc;
  logic rnd_inexact;

  fpr_round_inc u_round_inc (
    .rmode_i  (rmode),
    .sign_i   (sign_i),
    .lsb_i    (den_frac[0]),
    .guard_i  (den_guard),
    .sticky_i (den_sticky),
    .inc_o    (rnd_inc),
    .inexact_o(rnd_inexact)
  );

  logic [MAG_W-1:0] ovf_mag;

  fpr_ovf_sel #(
    .EXP_W(EXP_W), .MAN_W(MAN_W)
  ) u_ovf_sel (
    .rmode_i(rmode),
    .sign_i (sign_i),
    .mag_o  (ovf_mag)
  );

  logic [EXP_W-1:0] field;
  logic [MAG_W-1:0] packed_mag;
  logic [MAG_W-1:0] rounded_mag;
  logic             pre_ovf;
  logic             post_ovf;
  logic             ovf;
  logic [MAG_W-1:0] mag_n;
  logic             ovf_n;
  logic             uf_n;
  logic             nx_n;

  assign field       = den_hidden ? exp_i[EXP_W-1:0] : '0;
  assign packed_mag  = {field, den_frac};
  // carry out of the fraction ripples into the exponent field
  assign rounded_mag = packed_mag + MAG_W'(rnd_inc);

  assign pre_ovf  = ~exp_i[EIN_W-1] & (exp_i >= EIN_W'(MAX_FIELD));
  assign post_ovf = &rounded_mag[MAG_W-1:MAN_W];
  assign ovf      = ~zero_in & (pre_ovf | post_ovf);

  always_comb begin
    if (zero_in) begin
      mag_n = '0;
      ovf_n = 1'b0;
      uf_n  = 1'b0;
      nx_n  = 1'b0;
    end else if (ovf) begin
      mag_n = ovf_mag;
      ovf_n = 1'b1;
      uf_n  = 1'b0;
      nx_n  = 1'b1;
    end else begin
      mag_n = rounded_mag;
      ovf_n = 1'b0;
      uf_n  = tiny & rnd_inexact;
      nx_n  = rnd_inexact;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      result_o    <= '0;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
      inexact_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o    <= {sign_i, mag_n};
        overflow_o  <= ovf_n;
        underflow_o <= uf_n;
        inexact_o   <= nx_n;
      end
    end
  end

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && !valid_o)); // R1
  AST_OVF_INEXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> inexact_o); // R5
  AST_OVF_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> (result_o[MAG_W-1:0] == INF_MAG || result_o[MAG_W-1:0] == MAXF_MAG)); // R5
  AST_UF_INEXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> inexact_o); // R8
  AST_UF_NOT_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(underflow_o && overflow_o)); // R9
  AST_NO_NAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((&result_o[MAG_W-1:MAN_W]) && (|result_o[MAN_W-1:0]))); // R2
  AST_TINY_NO_HIDDEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && tiny) |-> !den_hidden); // R7
  AST_ZERO_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && zero_in) |=> !(overflow_o || underflow_o || inexact_o)); // R10
endmodule

// File: tb/fpr_round_pack_bench.sv
module fpr_round_pack_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        sign_i = 1'b0;
  logic [12:0] exp_i = '0;
  logic [52:0] sig_i = '0;
  logic        guard_i = 1'b0;
  logic        sticky_i = 1'b0;
  logic [1:0]  rmode_i = 2'b00;
  logic        valid_o;
  logic [63:0] result_o;
  logic        overflow_o;
  logic        underflow_o;
  logic        inexact_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [52:0] ONE  = 53'h10_0000_0000_0000;
  localparam logic [52:0] ALL1 = 53'h1F_FFFF_FFFF_FFFF;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] PMAX = 64'h7FEF_FFFF_FFFF_FFFF;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] NMAX = 64'hFFEF_FFFF_FFFF_FFFF;

  always #5 clk_i = ~clk_i;

  fpr_round_pack u_fpr_round_pack (
    .clk_i, .rst_ni, .valid_i, .sign_i, .exp_i, .sig_i, .guard_i, .sticky_i,
    .rmode_i, .valid_o, .result_o, .overflow_o, .underflow_o, .inexact_o
  );

  task automatic expect_out(string req, logic [63:0] er, logic eo, logic eu, logic ex);
    checks++;
    if (result_o !== er || overflow_o !== eo || underflow_o !== eu || inexact_o !== ex
        || valid_o !== 1'b1) begin
      failures++;
      $display("FAIL %s: actual=%h o%b u%b x%b v%b expected=%h o%b u%b x%b v1",
               req, result_o, overflow_o, underflow_o, inexact_o, valid_o, er, eo, eu, ex);
    end
  endtask

  // drive on falling edge, capture on rising edge, sample on next falling edge
  task automatic apply(logic s, int e, logic [52:0] m, logic g, logic st, logic [1:0] rm);
    @(negedge clk_i);
    valid_i = 1'b1; sign_i = s; exp_i = 13'(e); sig_i = m;
    guard_i = g; sticky_i = st; rmode_i = rm;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic t_reset();
    checks++;
    if (valid_o !== 1'b0 || result_o !== '0 || overflow_o !== 1'b0 ||
        underflow_o !== 1'b0 || inexact_o !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset: actual=%h v%b expected=0 v0", result_o, valid_o);
    end
  endtask

  task automatic t_hold();
    apply(1'b0, 1023, ONE, 1'b0, 1'b0, 2'b00);
    expect_out("R1 one", 64'h3FF0_0000_0000_0000, 0, 0, 0);
    @(negedge clk_i);
    checks++;
    if (valid_o !== 1'b0 || result_o !== 64'h3FF0_0000_0000_0000) begin
      failures++;
      $display("FAIL R1 hold: actual=%h v%b expected=3ff0000000000000 v0", result_o, valid_o);
    end
  endtask

  task automatic t_square_ulp();
    apply(1'b0, 1023, ONE | 53'd2, 1'b0, 1'b1, 2'b00);
    expect_out("R2 nearest", 64'h3FF0_0000_0000_0002, 0, 0, 1);
    apply(1'b0, 1023, ONE | 53'd2, 1'b0, 1'b1, 2'b01);
    expect_out("R3 zero", 64'h3FF0_0000_0000_0002, 0, 0, 1);
    apply(1'b0, 1023, ONE | 53'd2, 1'b0, 1'b1, 2'b10);
    expect_out("R3 up", 64'h3FF0_0000_0000_0003, 0, 0, 1);
    apply(1'b0, 1023, ONE | 53'd2, 1'b0, 1'b1, 2'b11);
    expect_out("R3 down", 64'h3FF0_0000_0000_0002, 0, 0, 1);
  endtask

  task automatic t_ties();
    apply(1'b0, 1023, ONE | 53'd1, 1'b1, 1'b0, 2'b00);
    expect_out("R2 tie odd", 64'h3FF0_0000_0000_0002, 0, 0, 1);
    apply(1'b0, 1023, ONE | 53'd2, 1'b1, 1'b0, 2'b00);
    expect_out("R2 tie even", 64'h3FF0_0000_0000_0002, 0, 0, 1);
  endtask

  task automatic t_negative();
    apply(1'b1, 1023, ONE | 53'd2, 1'b0, 1'b1, 2'b11);
    expect_out("R3 neg down", 64'hBFF0_0000_0000_0003, 0, 0, 1);
    apply(1'b1, 1023, ONE | 53'd2, 1'b0, 1'b1, 2'b10);
    expect_out("R3 neg up", 64'hBFF0_0000_0000_0002, 0, 0, 1);
  endtask

  task automatic t_carry();
    apply(1'b0, 1023, ALL1, 1'b1, 1'b0, 2'b00);
    expect_out("R4 carry", 64'h4000_0000_0000_0000, 0, 0, 1);
    apply(1'b0, 2046, ALL1, 1'b1, 1'b0, 2'b00);
    expect_out("R4 carry ovf", PINF, 1, 0, 1);
    apply(1'b0, 2046, ALL1, 1'b1, 1'b0, 2'b01);
    expect_out("R4 no carry", PMAX, 0, 0, 1);
  endtask

  task automatic t_ovf_pos();
    apply(1'b0, 2047, ONE, 1'b0, 1'b0, 2'b00);
    expect_out("R5 nearest", PINF, 1, 0, 1);
    apply(1'b0, 2047, ONE, 1'b0, 1'b0, 2'b01);
    expect_out("R5 zero", PMAX, 1, 0, 1);
    apply(1'b0, 3000, ONE, 1'b0, 1'b0, 2'b10);
    expect_out("R5 up", PINF, 1, 0, 1);
    apply(1'b0, 2047, ONE, 1'b0, 1'b0, 2'b11);
    expect_out("R5 down", PMAX, 1, 0, 1);
  endtask

  task automatic t_ovf_neg();
    apply(1'b1, 2047, ONE, 1'b0, 1'b0, 2'b00);
    expect_out("R6 nearest", NINF, 1, 0, 1);
    apply(1'b1, 2047, ONE, 1'b0, 1'b0, 2'b01);
    expect_out("R6 zero", NMAX, 1, 0, 1);
    apply(1'b1, 2047, ONE, 1'b0, 1'b0, 2'b10);
    expect_out("R6 up", NMAX, 1, 0, 1);
    apply(1'b1, 2047, ONE, 1'b0, 1'b0, 2'b11);
    expect_out("R6 down", NINF, 1, 0, 1);
  endtask

  task automatic t_denorm();
    apply(1'b0, -51, ONE, 1'b0, 1'b0, 2'b00);
    expect_out("R8 exact denormal", 64'h0000_0000_0000_0001, 0, 0, 0);
    apply(1'b0, 0, ALL1, 1'b0, 1'b0, 2'b00);
    expect_out("R7 round to min normal", 64'h0010_0000_0000_0000, 0, 1, 1);
    apply(1'b0, -52, ONE, 1'b0, 1'b0, 2'b00);
    expect_out("R7 half tie", 64'h0, 0, 1, 1);
    apply(1'b0, -52, ONE, 1'b0, 1'b0, 2'b10);
    expect_out("R7 half up", 64'h1, 0, 1, 1);
  endtask

  task automatic t_far_tiny();
    apply(1'b0, -1021, ONE, 1'b0, 1'b0, 2'b00);
    expect_out("R9 nearest", 64'h0, 0, 1, 1);
    apply(1'b0, -1021, ONE, 1'b0, 1'b0, 2'b01);
    expect_out("R9 zero", 64'h0, 0, 1, 1);
    apply(1'b0, -1021, ONE, 1'b0, 1'b0, 2'b10);
    expect_out("R9 up", 64'h1, 0, 1, 1);
    apply(1'b0, -1021, ONE, 1'b0, 1'b0, 2'b11);
    expect_out("R9 down", 64'h0, 0, 1, 1);
    apply(1'b1, -1021, ONE, 1'b0, 1'b0, 2'b11);
    expect_out("R9 neg down", 64'h8000_0000_0000_0001, 0, 1, 1);
    apply(1'b1, -1021, ONE, 1'b0, 1'b0, 2'b10);
    expect_out("R9 neg up", 64'h8000_0000_0000_0000, 0, 1, 1);
  endtask

  task automatic t_zero();
    apply(1'b1, 5000, '0, 1'b1, 1'b1, 2'b11);
    expect_out("R10 neg zero", 64'h8000_0000_0000_0000, 0, 0, 0);
    apply(1'b0, -7, '0, 1'b0, 1'b0, 2'b10);
    expect_out("R10 pos zero", 64'h0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_hold();
    t_square_ulp();
    t_ties();
    t_negative();
    t_carry();
    t_ovf_pos();
    t_ovf_neg();
    t_denorm();
    t_far_tiny();
    t_zero();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule